// File: doc/BRIEF.md
# Branch Direction Predictor Table with Outcome Queue

This block predicts whether a conditional branch will be taken. It keeps a direct-mapped table of two-bit saturating counters, indexed by a slice of the branch address. The fetch stage presents an address on the lookup port and receives the counter value and a taken/not-taken prediction in the same cycle.

Resolved branches return on two independent update lanes, so up to two outcomes can arrive in one cycle. The counter table has only one write port. A short first-in first-out outcome queue therefore absorbs the outcomes and retires one per cycle through a read-modify-write of the addressed counter. An outcome is lost only when the queue has no room for it. Lost outcomes are counted and the shortage is flagged.

A controller with two named states sequences the table. `ST_SWEEP` is entered on reset and writes the weakly-not-taken value into one entry per cycle while `busy` is high. The transition `ST_SWEEP -> ST_RUN` happens on the cycle that writes the last entry. In `ST_RUN` the controller drains one queued outcome per cycle whenever the queue is not empty. `ST_RUN` has no outgoing transition except reset.

Top module: `branch_history_table`

## Requirements
- R1: The lookup output `lk_ctr` is the stored counter at index `lk_addr[11:2]` (address bits above and below that slice are ignored), and `lk_taken` equals bit 1 of that counter. The lookup is combinational.
- R2: Applying an outcome increments the addressed counter when taken and decrements it when not taken, saturating at 0 and 3.
- R3: Synchronous reset empties the queue and clears `drop_count`. After reset is released, `busy` stays high for exactly ENTRIES (1024) clock edges, and then every counter reads 1.
- R4: When both lanes are valid in one cycle, both outcomes are recorded, lane 0 before lane 1. A lone lane 1 outcome is also recorded.
- R5: Two queued outcomes for the same index are applied in order, so the second one sees the result of the first.
- R6: The table takes one write per cycle. A lane 0 outcome presented before edge k (queue empty) is queued at edge k and visible at lookup after edge k+1. Its lane 1 partner becomes visible after edge k+2.
- R7: A lookup at an index that has a queued but unapplied outcome returns the stored value, not the pending one.
- R8: `upd_full` is high whenever the queue has fewer than two free slots (occupancy of QDEPTH-1 or more), judged from the occupancy before the edge.
- R9: An outcome that finds no free slot is dropped and `drop_count` increments by one for each dropped outcome. With one free slot, lane 0 takes it and lane 1 is dropped.
- R10: Outcomes that arrive while `busy` is high are queued and applied once the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Fetch address for prediction lookup |
| lk_ctr | output | 2 | Stored counter at the looked-up index |
| lk_taken | output | 1 | Predicted taken |
| up0_valid | input | 1 | Lane 0 outcome valid |
| up0_addr | input | ADDR_W | Lane 0 branch address |
| up0_taken | input | 1 | Lane 0 branch was taken |
| up1_valid | input | 1 | Lane 1 outcome valid |
| up1_addr | input | ADDR_W | Lane 1 branch address |
| up1_taken | input | 1 | Lane 1 branch was taken |
| upd_full | output | 1 | Queue cannot accept two outcomes this cycle |
| drop_count | output | DROP_W | Saturating count of dropped outcomes |
| busy | output | 1 | Reset sweep in progress |

## Verification
The lookup result is read in the same cycle the address is applied. An outcome presented before an edge enters the queue at that edge. A lane 0 outcome reaches the table one edge later, and its lane 1 partner reaches it two edges later. `upd_full` depends only on the occupancy before the edge, while `drop_count` changes at that edge. The bench drives and samples 1 ns after each rising edge and counts edges explicitly, so each value is read in the first cycle it is due. For R7, it also reads the value in the cycle just before the write lands.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } bht_state_e;

    localparam logic [1:0] CTR_INIT = 2'b01;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == 2'b11) ? cur : cur + 2'b01;
        end else begin
            nxt = (cur == 2'b00) ? cur : cur - 2'b01;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bht_counter_array.sv
module bht_counter_array #(
    parameter int IDX_W   = 10,
    parameter int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_is_init,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_data,
    input  logic [IDX_W-1:0] rda_idx,
    output logic [1:0]       rda_data,
    input  logic [IDX_W-1:0] rdb_idx,
    output logic [1:0]       rdb_data
);

    logic [1:0] ctr_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ctr_q[wr_idx] <= wr_data;
        end
    end

    assign rda_data = ctr_q[rda_idx];
    assign rdb_data = ctr_q[rdb_idx];

    // R2: a training write targets the entry just read and moves it by at most one step
    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_is_init) |-> ((wr_idx == rdb_idx) && ((wr_data - rdb_data) != 2'b10)));

endmodule

// File: rtl/bht_update_queue.sv
module bht_update_queue #(
    parameter int IDX_W  = 10,
    parameter int DEPTH  = 4,   // power of two
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in0_valid,
    input  logic [IDX_W-1:0]  in0_idx,
    input  logic              in0_taken,
    input  logic              in1_valid,
    input  logic [IDX_W-1:0]  in1_idx,
    input  logic              in1_taken,
    input  logic              pop,
    output logic              nonempty,
    output logic [IDX_W-1:0]  head_idx,
    output logic              head_taken,
    output logic              full,
    output logic [DROP_W-1:0] drop_count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [IDX_W-1:0]  idx_mem [DEPTH];
    logic              tk_mem  [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  free_slots;
    logic              acc0, acc1;
    logic [1:0]        n_push, n_drop;
    logic [PTR_W-1:0]  wr1_ptr;
    logic [DROP_W-1:0] drop_q;

    always_comb begin
        free_slots = CNT_W'(DEPTH) - count_q;
        acc0       = in0_valid && (free_slots >= CNT_W'(1));
        acc1       = in1_valid && (free_slots >= (acc0 ? CNT_W'(2) : CNT_W'(1)));
        n_push     = {1'b0, acc0} + {1'b0, acc1};
        n_drop     = {1'b0, in0_valid && !acc0} + {1'b0, in1_valid && !acc1};
        wr1_ptr    = acc0 ? wr_ptr_q + PTR_W'(1) : wr_ptr_q;
    end

    always_ff @(posedge clk) begin
        if (acc0) begin
            idx_mem[wr_ptr_q] <= in0_idx;
            tk_mem[wr_ptr_q]  <= in0_taken;
        end
        if (acc1) begin
            idx_mem[wr1_ptr] <= in1_idx;
            tk_mem[wr1_ptr]  <= in1_taken;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
            drop_q   <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + PTR_W'(n_push);
            rd_ptr_q <= rd_ptr_q + PTR_W'(pop);
            count_q  <= count_q + CNT_W'(n_push) - CNT_W'(pop);
            if (n_drop != 2'd0) begin
                if (drop_q > {DROP_W{1'b1}} - DROP_W'(n_drop)) begin
                    drop_q <= {DROP_W{1'b1}};
                end else begin
                    drop_q <= drop_q + DROP_W'(n_drop);
                end
            end
        end
    end

    assign nonempty   = (count_q != '0);
    assign head_idx   = idx_mem[rd_ptr_q];
    assign head_taken = tk_mem[rd_ptr_q];
    assign full       = (free_slots < CNT_W'(2));
    assign drop_count = drop_q;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count_q != '0));

    assert_no_drop_unless_full_R9: assert property (@(posedge clk) disable iff (rst)
        (!full && !(in0_valid && !in1_valid && count_q == CNT_W'(DEPTH)))
        |=> (drop_count == $past(drop_count)));

endmodule

// File: rtl/bht_ctrl.sv
module bht_ctrl
    import bht_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_nonempty,
    input  logic [IDX_W-1:0] head_idx,
    input  logic             head_taken,
    input  logic [1:0]       head_ctr,
    output logic             busy,
    output logic             pop,
    output logic             wr_en,
    output logic             wr_is_init,
    output logic [IDX_W-1:0] wr_idx,
    output logic [1:0]       wr_data
);

    bht_state_e       state_q;
    logic [IDX_W-1:0] sweep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SWEEP;
            sweep_q <= '0;
        end else begin
            unique case (state_q)
                ST_SWEEP: begin
                    sweep_q <= sweep_q + IDX_W'(1);
                    if (sweep_q == IDX_W'(ENTRIES - 1)) begin
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    state_q <= ST_RUN;
                end
                default: state_q <= ST_SWEEP;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b0;
        pop        = 1'b0;
        wr_en      = 1'b0;
        wr_is_init = 1'b0;
        wr_idx     = head_idx;
        wr_data    = ctr_step(head_ctr, head_taken);
        unique case (state_q)
            ST_SWEEP: begin
                busy       = 1'b1;
                wr_en      = 1'b1;
                wr_is_init = 1'b1;
                wr_idx     = sweep_q;
                wr_data    = CTR_INIT;
            end
            ST_RUN: begin
                pop   = q_nonempty;
                wr_en = q_nonempty;
            end
            default: busy = 1'b1;
        endcase
    end

    assert_drain_after_sweep_R10: assert property (@(posedge clk) disable iff (rst)
        pop |-> !busy);

    assert_run_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

    assert_sweep_complete_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (sweep_q == '0));

endmodule

// File: rtl/branch_history_table.sv
module branch_history_table #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 10,
    parameter int IDX_LSB = 2,
    parameter int QDEPTH  = 4,
    parameter int DROP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [1:0]        lk_ctr,
    output logic              lk_taken,
    input  logic              up0_valid,
    input  logic [ADDR_W-1:0] up0_addr,
    input  logic              up0_taken,
    input  logic              up1_valid,
    input  logic [ADDR_W-1:0] up1_addr,
    input  logic              up1_taken,
    output logic              upd_full,
    output logic [DROP_W-1:0] drop_count,
    output logic              busy
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic             q_nonempty, q_pop, q_head_taken;
    logic [IDX_W-1:0] q_head_idx;
    logic [1:0]       head_ctr;
    logic             wr_en, wr_is_init;
    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       wr_data;

    bht_update_queue #(
        .IDX_W (IDX_W),
        .DEPTH (QDEPTH),
        .DROP_W(DROP_W)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .in0_valid (up0_valid),
        .in0_idx   (up0_addr[IDX_MSB:IDX_LSB]),
        .in0_taken (up0_taken),
        .in1_valid (up1_valid),
        .in1_idx   (up1_addr[IDX_MSB:IDX_LSB]),
        .in1_taken (up1_taken),
        .pop       (q_pop),
        .nonempty  (q_nonempty),
        .head_idx  (q_head_idx),
        .head_taken(q_head_taken),
        .full      (upd_full),
        .drop_count(drop_count)
    );

    bht_ctrl #(
        .IDX_W  (IDX_W),
        .ENTRIES(ENTRIES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .q_nonempty(q_nonempty),
        .head_idx  (q_head_idx),
        .head_taken(q_head_taken),
        .head_ctr  (head_ctr),
        .busy      (busy),
        .pop       (q_pop),
        .wr_en     (wr_en),
        .wr_is_init(wr_is_init),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    bht_counter_array #(
        .IDX_W  (IDX_W),
        .ENTRIES(ENTRIES)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_is_init(wr_is_init),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rda_idx   (lk_addr[IDX_MSB:IDX_LSB]),
        .rda_data  (lk_ctr),
        .rdb_idx   (q_head_idx),
        .rdb_data  (head_ctr)
    );

    assign lk_taken = lk_ctr[1];

endmodule

// File: tb/test_branch_history_table.sv
module test_branch_history_table;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_ctr;
    logic        lk_taken;
    logic        up0_valid = 1'b0, up0_taken = 1'b0;
    logic        up1_valid = 1'b0, up1_taken = 1'b0;
    logic [31:0] up0_addr = '0, up1_addr = '0;
    logic        upd_full;
    logic [15:0] drop_count;
    logic        busy;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    branch_history_table i_branch_history_table (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_ctr(lk_ctr), .lk_taken(lk_taken),
        .up0_valid(up0_valid), .up0_addr(up0_addr), .up0_taken(up0_taken),
        .up1_valid(up1_valid), .up1_addr(up1_addr), .up1_taken(up1_taken),
        .upd_full(upd_full), .drop_count(drop_count), .busy(busy)
    );

    typedef struct packed {
        logic        v0;
        logic [31:0] a0;
        logic        t0;
        logic        v1;
        logic [31:0] a1;
        logic        t1;
        logic [31:0] look;
        logic [1:0]  exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'h14,   1'b1, 1'b0, 32'h0,  1'b0, 32'h14, 2'd2},  // R2 inc
        '{1'b1, 32'h14,   1'b1, 1'b0, 32'h0,  1'b0, 32'h14, 2'd3},  // R2 inc
        '{1'b1, 32'h14,   1'b1, 1'b0, 32'h0,  1'b0, 32'h14, 2'd3},  // R2 sat high
        '{1'b1, 32'h18,   1'b0, 1'b0, 32'h0,  1'b0, 32'h18, 2'd0},  // R2 dec
        '{1'b1, 32'h18,   1'b0, 1'b0, 32'h0,  1'b0, 32'h18, 2'd0},  // R2 sat low
        '{1'b1, 32'h1C,   1'b1, 1'b1, 32'h1C, 1'b1, 32'h1C, 2'd3},  // R5 same idx
        '{1'b1, 32'h20,   1'b1, 1'b1, 32'h24, 1'b0, 32'h20, 2'd2},  // R4 lane0
        '{1'b0, 32'h0,    1'b0, 1'b1, 32'h28, 1'b1, 32'h28, 2'd2},  // R4 lane1 alone
        '{1'b1, 32'h2C,   1'b1, 1'b1, 32'h2C, 1'b0, 32'h2C, 2'd1},  // R5 ordered
        '{1'b1, 32'h1033, 1'b1, 1'b0, 32'h0,  1'b0, 32'h30, 2'd2}   // R1 alias bits
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] a);
        lk_addr = a;
        #1;
    endtask

    task automatic idle_lanes();
        up0_valid = 1'b0;
        up1_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int busy_edges;
        int bad_init;
        tick();
        tick();
        chk("R3 busy in reset", {31'b0, busy}, 32'd1);
        chk("R3 drop cleared", {16'b0, drop_count}, 32'd0);
        chk("R3 queue empty not full", {31'b0, upd_full}, 32'd0);
        rst = 1'b0;
        // R10: outcome during sweep, idx 20
        up0_valid = 1'b1; up0_addr = 32'h50; up0_taken = 1'b1;
        busy_edges = 0;
        tick();
        busy_edges++;
        idle_lanes();
        while (busy && busy_edges < 5000) begin
            tick();
            busy_edges++;
        end
        chk("R3 sweep length", busy_edges, 32'd1024);
        bad_init = 0;
        for (int i = 0; i < 1024; i++) begin
            if (i != 20) begin
                look(32'(i) << 2);
                if (lk_ctr !== 2'd1 || lk_taken !== 1'b0) bad_init++;
            end
        end
        chk("R3 all counters weakly not-taken", bad_init, 32'd0);
        tick();
        look(32'h50);
        chk("R10 update queued during busy applied", {30'b0, lk_ctr}, 32'd2);

        // table of vectors: R1 R2 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            up0_valid = VECS[v].v0; up0_addr = VECS[v].a0; up0_taken = VECS[v].t0;
            up1_valid = VECS[v].v1; up1_addr = VECS[v].a1; up1_taken = VECS[v].t1;
            tick();
            idle_lanes();
            tick(); tick(); tick();
            look(VECS[v].look);
            chk($sformatf("R1/R2/R4/R5 vector %0d ctr", v), {30'b0, lk_ctr}, {30'b0, VECS[v].exp});
            chk($sformatf("R1 vector %0d taken bit", v), {31'b0, lk_taken}, {31'b0, VECS[v].exp[1]});
        end
        look(32'h24);
        chk("R4 lane1 of pair recorded", {30'b0, lk_ctr}, 32'd0);

        // R6 / R7 timing, idx 30 and 31
        up0_valid = 1'b1; up0_addr = 32'h78; up0_taken = 1'b1;
        up1_valid = 1'b1; up1_addr = 32'h7C; up1_taken = 1'b1;
        tick();
        idle_lanes();
        look(32'h78);
        chk("R7 pending not visible", {30'b0, lk_ctr}, 32'd1);
        tick();
        look(32'h78);
        chk("R6 lane0 visible after second edge", {30'b0, lk_ctr}, 32'd2);
        look(32'h7C);
        chk("R6 lane1 not yet written", {30'b0, lk_ctr}, 32'd1);
        tick();
        look(32'h7C);
        chk("R6 lane1 visible after third edge", {30'b0, lk_ctr}, 32'd2);

        // R8 / R9 fill the queue, idx 40..45
        chk("R8 not full when empty", {31'b0, upd_full}, 32'd0);
        up0_valid = 1'b1; up0_addr = 32'hA0; up0_taken = 1'b1;
        up1_valid = 1'b1; up1_addr = 32'hA4; up1_taken = 1'b1;
        tick();
        chk("R8 not full with two queued", {31'b0, upd_full}, 32'd0);
        up0_addr = 32'hA8; up1_addr = 32'hAC;
        tick();
        chk("R8 full with three queued", {31'b0, upd_full}, 32'd1);
        chk("R9 no drop yet", {16'b0, drop_count}, 32'd0);
        up0_addr = 32'hB0; up1_addr = 32'hB4;
        tick();
        idle_lanes();
        chk("R9 one drop counted", {16'b0, drop_count}, 32'd1);
        repeat (6) tick();
        look(32'hB0);
        chk("R9 lane0 took the last slot", {30'b0, lk_ctr}, 32'd2);
        look(32'hB4);
        chk("R9 lane1 dropped, no effect", {30'b0, lk_ctr}, 32'd1);
        look(32'hAC);
        chk("R9 earlier lane1 kept", {30'b0, lk_ctr}, 32'd2);
        chk("R8 full clears after drain", {31'b0, upd_full}, 32'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule